// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

This block is a single-port synchronous static memory with late-write timing. On each rising clock edge it registers the command: select, write enable, address and per-lane byte enables. For a write, the data word arrives on the following rising edge. The word is placed in a one-entry pending buffer and reaches the array only when the next write's data arrives. A read registered on a rising edge drives its data after the falling edge of the same cycle. A read that hits the buffered address sees the buffered lanes, so read-after-write is coherent.

An asynchronous output enable and a sleep input control whether the output is driven. Sleep also blocks new commands and keeps the stored contents. The word is built from `LANES` lanes of `LANE_W` bits each. The depth is `2**ADDR_W`. The pad driver is outside the block: `dq_oe_o` is its enable, and `dq_o` is zero whenever that enable is low.

Top module: `lw_sram`

## Requirements
- R1: A read registered on a rising edge drives `dq_oe_o` high, and `dq_o` shows the addressed word, from the falling edge of that same cycle until the next falling edge, provided `oe_i` is high and `sleep_i` is low.
- R2: The data for a write is sampled from `wdata_i` on the rising edge one cycle after the edge that registered the write's address and controls.
- R3: `bw_i[i]` enables lane i, which is bits `[i*LANE_W +: LANE_W]`. A write updates only its enabled lanes, and a write with `bw_i` all zero leaves the word unchanged.
- R4: A read whose address equals the buffered write's address returns the buffered lanes that the write enabled, merged with the array's other lanes.
- R5: The buffered write goes into the array on the edge that samples the next write's data. Back-to-back writes to different addresses both end up stored.
- R6: A cycle with `sel_i` low changes neither the array nor the pending buffer, whatever `we_i` is. After that cycle's falling edge the output is not driven.
- R7: After the falling edge of a write cycle, the output is not driven.
- R8: With `oe_i` low, `dq_oe_o` is low and `dq_o` is zero at once, with no clock edge needed. Raising `oe_i` again restores the latched word.
- R9: While `sleep_i` is high, commands are ignored and the output is not driven. Array contents are kept.
- R10: While `rst_ni` is low, the output is not driven and the pending buffer is empty. The array is not cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; commands on the rising edge, read output on the falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Low-power request; blocks commands and the output drive |
| sel_i | input | 1 | Synchronous select |
| we_i | input | 1 | Write enable (1 = write, 0 = read) |
| addr_i | input | ADDR_W | Word address |
| bw_i | input | LANES | Per-lane write enables |
| wdata_i | input | LANES*LANE_W | Write data, one cycle after its command |
| oe_i | input | 1 | Asynchronous output enable |
| dq_o | output | LANES*LANE_W | Read data; zero when not driven |
| dq_oe_o | output | 1 | Output driver enable |

## Verification
The assertions assume that `sleep_i` and `oe_i` change only away from the rising edge. This lets the preponed sample of `sleep_i` at a rising edge match the value that gated the output during the cycle before it. They also assume that any rise of `rst_ni` falls between clock edges. The stimulus drives every input three quarters of a period after a rising edge. Asynchronous toggles of `oe_i` and `sleep_i` happen only in the gap before the next rising edge. Reset is released the same way.

// File: rtl/lw_sram_pkg.sv
`timescale 1ns/1ps
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_sram_cmd.sv
`timescale 1ns/1ps
module lw_sram_cmd
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  bw_o
);
  op_e op_d;

  always_comb begin
    if (sleep_i || !sel_i) op_d = OP_IDLE;
    else if (we_i)         op_d = OP_WRITE;
    else                   op_d = OP_READ;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= OP_IDLE;
      addr_o <= '0;
      bw_o   <= '0;
    end else begin
      op_o   <= op_d;
      addr_o <= addr_i;
      bw_o   <= bw_i;
    end
  end

  AST_SLEEP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (op_o == OP_IDLE)); // R9
endmodule

// File: rtl/lw_sram_wbuf.sv
`timescale 1ns/1ps
module lw_sram_wbuf #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANES-1:0]  wr_bw_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] cm_addr_o,
  output logic [LANES-1:0]  cm_bw_o,
  output logic [DATA_W-1:0] cm_data_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_bw;
  logic [DATA_W-1:0] pend_data;
  logic              hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      pend_bw    <= '0;
      pend_data  <= '0;
    end else if (wr_i) begin
      pend_valid <= 1'b1;
      pend_addr  <= wr_addr_i;
      pend_bw    <= wr_bw_i;
      pend_data  <= wdata_i;
    end
  end

  // the older entry leaves as the newer one's data lands
  assign commit_o  = wr_i && pend_valid;
  assign cm_addr_o = pend_addr;
  assign cm_bw_o   = pend_bw;
  assign cm_data_o = pend_data;
  assign hit       = pend_valid && (pend_addr == rd_addr_i);

  for (genvar g = 0; g < LANES; g++) begin : g_merge
    assign rdata_o[g*LANE_W +: LANE_W] = (hit && pend_bw[g]) ?
      pend_data[g*LANE_W +: LANE_W] : arr_rdata_i[g*LANE_W +: LANE_W];
  end

  AST_WBUF_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> pend_valid && pend_addr == $past(wr_addr_i)
             && pend_data == $past(wdata_i)); // R2
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(pend_valid) && $stable(pend_addr)
              && $stable(pend_bw) && $stable(pend_data)); // R6
endmodule

// File: rtl/lw_sram_array.sv
`timescale 1ns/1ps
module lw_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANES-1:0]  wr_bw_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_bw_i[l]) mem[wr_addr_i][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/lw_sram_out.sv
`timescale 1ns/1ps
module lw_sram_out #(
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              oe_i,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  logic              valid_q;
  logic [DATA_W-1:0] dout_q;

  // falling-edge stage: data appears half a cycle after the command edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      valid_q <= rd_i;
      if (rd_i) dout_q <= rdata_i;
    end
  end

  assign dq_oe_o = oe_i && !sleep_i && valid_q;
  assign dq_o    = dq_oe_o ? dout_q : '0;
endmodule

// File: rtl/lw_sram.sv
`timescale 1ns/1ps
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o
);
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  bw_q;
  logic              commit;
  logic [ADDR_W-1:0] cm_addr;
  logic [LANES-1:0]  cm_bw;
  logic [DATA_W-1:0] cm_data;
  logic [DATA_W-1:0] arr_rdata;
  logic [DATA_W-1:0] merged;

  lw_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk_i, .rst_ni, .sleep_i, .sel_i, .we_i, .addr_i, .bw_i,
    .op_o(op_q), .addr_o(addr_q), .bw_o(bw_q)
  );

  lw_sram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk_i, .rst_ni,
    .wr_i(op_q == OP_WRITE), .wr_addr_i(addr_q), .wr_bw_i(bw_q), .wdata_i,
    .rd_addr_i(addr_q), .arr_rdata_i(arr_rdata),
    .commit_o(commit), .cm_addr_o(cm_addr), .cm_bw_o(cm_bw), .cm_data_o(cm_data),
    .rdata_o(merged)
  );

  lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .we_i(commit), .wr_addr_i(cm_addr), .wr_bw_i(cm_bw), .wr_data_i(cm_data),
    .rd_addr_i(addr_q), .rd_data_o(arr_rdata)
  );

  lw_sram_out #(.DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni, .rd_i(op_q == OP_READ), .rdata_i(merged),
    .oe_i, .sleep_i, .dq_o, .dq_oe_o
  );

  AST_NONREAD_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_READ) |-> !dq_oe_o); // R7
  AST_READ_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_READ && oe_i && !sleep_i) |-> dq_oe_o); // R1
endmodule

// File: tb/sim_lw_sram.sv
`timescale 1ns/1ps
module sim_lw_sram;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;
  localparam int NV = 18;

  localparam logic [DW-1:0] D0 = 36'h123456789;
  localparam logic [DW-1:0] D1 = 36'hFEDCBA987;
  localparam logic [DW-1:0] D2 = 36'h0F0F0F0F0;
  localparam logic [DW-1:0] D3 = 36'h9ABCDEF01;
  localparam logic [DW-1:0] M1 = {D1[35:18], D2[17:0]};
  localparam logic [DW-1:0] M2 = {D3[35:27], D0[26:0]};
  localparam logic [DW-1:0] Z  = '0;

  typedef struct packed {
    logic          sel;
    logic          we;
    logic [AW-1:0] addr;
    logic [NL-1:0] bw;
    logic [DW-1:0] wd;   // data phase of the previous row's write
    logic          ev;
    logic [DW-1:0] ed;
    logic [3:0]    req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 8'd10, 4'hF, Z,  1'b0, Z,  4'd7},  // R7 write a10
    '{1'b1, 1'b1, 8'd20, 4'hF, D0, 1'b0, Z,  4'd7},  // R7 write a20, data a10
    '{1'b1, 1'b0, 8'd10, 4'hF, D1, 1'b1, D0, 4'd1},  // R1 read a10 same-cycle falling edge
    '{1'b1, 1'b0, 8'd20, 4'h0, Z,  1'b1, D1, 4'd4},  // R4 hit on buffered write
    '{1'b1, 1'b1, 8'd20, 4'h3, Z,  1'b0, Z,  4'd7},  // R7 partial write a20
    '{1'b1, 1'b0, 8'd20, 4'h0, D2, 1'b1, M1, 4'd3},  // R3 lanes 0,1 merged
    '{1'b0, 1'b0, 8'd0,  4'h0, Z,  1'b0, Z,  4'd6},  // R6 deselect
    '{1'b1, 1'b0, 8'd20, 4'h0, Z,  1'b1, M1, 4'd6},  // R6 buffer survived deselect
    '{1'b1, 1'b1, 8'd10, 4'h8, Z,  1'b0, Z,  4'd7},  // R7 lane 3 write a10
    '{1'b0, 1'b1, 8'd55, 4'hF, D3, 1'b0, Z,  4'd6},  // R6 deselect with we high
    '{1'b1, 1'b0, 8'd10, 4'h0, Z,  1'b1, M2, 4'd3},  // R3 lane 3 only
    '{1'b1, 1'b0, 8'd20, 4'h0, Z,  1'b1, M1, 4'd5},  // R5 committed to array
    '{1'b1, 1'b1, 8'd10, 4'h0, Z,  1'b0, Z,  4'd7},  // R7 null-mask write
    '{1'b1, 1'b0, 8'd10, 4'h0, D1, 1'b1, M2, 4'd3},  // R3 null mask leaves word
    '{1'b1, 1'b1, 8'd40, 4'hF, Z,  1'b0, Z,  4'd5},  // R5 back-to-back write 1
    '{1'b1, 1'b1, 8'd41, 4'hF, D2, 1'b0, Z,  4'd5},  // R5 back-to-back write 2
    '{1'b1, 1'b0, 8'd40, 4'h0, D3, 1'b1, D2, 4'd2},  // R2 data one edge late
    '{1'b1, 1'b0, 8'd41, 4'h0, Z,  1'b1, D3, 4'd4}   // R4 buffered read
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sleep_i = 1'b0;
  logic          sel_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [NL-1:0] bw_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          oe_i = 1'b1;
  logic [DW-1:0] dq_o;
  logic          dq_oe_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk_i = ~clk_i;

  lw_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u0 (
    .clk_i, .rst_ni, .sleep_i, .sel_i, .we_i, .addr_i, .bw_i, .wdata_i,
    .oe_i, .dq_o, .dq_oe_o
  );

  task automatic expect_out(input string tag, input logic ev, input logic [DW-1:0] ed);
    checks++;
    if (dq_oe_o !== ev || dq_o !== (ev ? ed : Z)) begin
      fails++;
      $display("FAIL %s: oe=%0b dq=%h expected oe=%0b dq=%h", tag, dq_oe_o, dq_o, ev,
               ev ? ed : Z);
    end
  endtask

  task automatic drive(input logic s, input logic w, input logic [AW-1:0] a,
                       input logic [NL-1:0] b, input logic [DW-1:0] d);
    sel_i = s; we_i = w; addr_i = a; bw_i = b; wdata_i = d;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #3;
    expect_out("R10 reset", 1'b0, Z);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].sel, VEC[i].we, VEC[i].addr, VEC[i].bw, VEC[i].wd);
      @(posedge clk_i);
      #3;
      expect_out($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].ev, VEC[i].ed);
    end
    // R8 output enable acts with no clock edge
    drive(1'b0, 1'b0, '0, '0, '0);
    oe_i = 1'b0;
    #0.3;
    expect_out("R8 oe low", 1'b0, Z);
    oe_i = 1'b1;
    #0.3;
    expect_out("R8 oe restored", 1'b1, D3);
    // R9 sleep blocks drive at once
    sleep_i = 1'b1;
    #0.3;
    expect_out("R9 sleep gates drive", 1'b0, Z);
    // R9 write issued during sleep is ignored
    drive(1'b1, 1'b1, 8'd40, 4'hF, '0);
    @(posedge clk_i);
    #3;
    expect_out("R9 sleep write", 1'b0, Z);
    drive(1'b1, 1'b0, 8'd40, 4'h0, D0);
    @(posedge clk_i);
    #3;
    expect_out("R9 sleep read", 1'b0, Z);
    sleep_i = 1'b0;
    drive(1'b1, 1'b0, 8'd40, 4'h0, '0);
    @(posedge clk_i);
    #3;
    expect_out("R9 contents kept after sleep", 1'b1, D2);
    drive(1'b0, 1'b0, '0, '0, '0);
    @(posedge clk_i);
    #3;
    expect_out("R6 idle after sleep", 1'b0, Z);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule